// File: doc/BRIEF.md
# End-of-Interrupt Broadcast Handler with Storm Throttle

This block sits beside the redirection table of an interrupt router and reacts to end-of-interrupt broadcasts. A broadcast names a vector and says whether it ends a level-type or an edge-type interrupt. The block walks the redirection entries one pin per clock cycle. It raises an acknowledge pulse on every pin whose vector matches the broadcast. For a level-type broadcast it also asks the table owner to drop that pin's remote-IRR bit, and it hands any request that is still pending straight to the delivery engine.

A guest that does not handle a level interrupt correctly can end each service with an EOI while the line is still asserted. This produces an endless chain of redeliveries. To catch this, each pin keeps a count of back-to-back EOI-driven redeliveries. When the count reaches its limit, the immediate redelivery is dropped and a one-shot timer is started. When the timer expires, a sweep over the whole table services every level pin that is still waiting. The remote-IRR bits, the pending bits and the message formation all stay outside the block, which only issues per-pin clear and service pulses.

Top module: `eoi_storm_throttle`

## Requirements
- R1: During the scan of a broadcast, each pin whose 8-bit entry vector equals the broadcast vector gets exactly one acknowledge pulse, whatever the entry's trigger mode and whatever the broadcast's type or directed flag. Pins that do not match get none.
- R2: A remote-IRR clear pulse goes out for a matching pin only when the broadcast is level-type (`eoi_is_level`=1) and `directed_eoi`=0. It is issued in the same cycle as that pin's acknowledge.
- R3: When a pin's remote IRR is cleared, and the pin is unmasked (`ent_mask` bit 0) and pending (`ent_pend` bit 1), its storm count increases by one. In the same cycle `svc_valid` is raised with `svc_pin` set to that pin, unless R5 applies.
- R4: When a pin's remote IRR is cleared while the pin is masked or not pending, its storm count returns to zero and no service request is issued.
- R5: When a redelivery would bring a pin's count to STORM_LIMIT, no service request is issued, the count returns to zero and the deferred sweep is scheduled.
- R6: A scheduled sweep starts no earlier than DEFER_CYCLES cycles after it was scheduled. It issues one service request for each pin that is level-triggered (`ent_level` bit 1), pending, unmasked and has remote IRR clear, and for no other pin.
- R7: Scheduling while a sweep is already waiting restarts the delay from the new scheduling point.
- R8: Reset cancels a scheduled sweep and clears every storm count.
- R9: Pins are scanned in ascending order, one per cycle, so a scan keeps `busy` high for NUM_PINS cycles. `eoi_ready` is low while a scan runs or a sweep is due.

Top module port order follows the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eoi_valid | input | 1 | Broadcast offered |
| eoi_ready | output | 1 | Broadcast accepted this cycle when high together with eoi_valid |
| eoi_vector | input | VEC_W | Vector being ended |
| eoi_is_level | input | 1 | 1 = level-type EOI, 0 = edge-type |
| directed_eoi | input | 1 | 1 = directed EOI mode, remote IRR left alone |
| ent_vector | input | NUM_PINS*VEC_W | Entry vectors, pin p at bits p*VEC_W upward |
| ent_level | input | NUM_PINS | Entry trigger mode, 1 = level |
| ent_mask | input | NUM_PINS | Entry mask, 1 = masked |
| ent_rirr | input | NUM_PINS | Entry remote-IRR bits |
| ent_pend | input | NUM_PINS | Pending request bits |
| ack_pulse | output | NUM_PINS | Per-pin acknowledge notification |
| rirr_clear | output | NUM_PINS | Per-pin request to clear remote IRR |
| svc_valid | output | 1 | Service request to the delivery engine |
| svc_pin | output | $clog2(NUM_PINS) | Pin to service |
| busy | output | 1 | A scan is in progress |

## Verification
The bench builds the block with four pins, a storm limit of four and a delay of sixty cycles. With these values a storm takes only four broadcasts to trigger, and the delayed sweep arrives after a few dozen cycles. This puts the threshold, the counter reset after a masked or idle pin, the restarted timer and the reset cancel within a short run. Three pins share one vector and one pin is edge-triggered, so a single broadcast shows the match, clear and service rules acting on several pins at once.

// File: rtl/est_pkg.sv
// Package: shared types for the EOI broadcast handler.
// Assumes: nothing beyond IEEE 1800-2017.
package est_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EOI   = 2'd1,
        ST_SWEEP = 2'd2
    } est_state_e;
endpackage

// File: rtl/est_defer_timer.sv
// Module: one-shot delay timer. An arm pulse loads DEFER_CYCLES and
// (re)starts the countdown; expire pulses once when it runs out.
// Assumes: DEFER_CYCLES >= 2; arm wins over a coinciding expiry.
module est_defer_timer #(
    parameter int DEFER_CYCLES = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expire
);
    localparam int TW = $clog2(DEFER_CYCLES + 1);

    logic [TW-1:0] cnt_q;
    logic          armed_q;

    // Expiry is the last counted cycle, suppressed by a restart.
    assign expire = armed_q && (cnt_q == TW'(1)) && !arm;

    // Load on arm, count down while armed, drop armed on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (arm) begin
            cnt_q   <= TW'(DEFER_CYCLES);
            armed_q <= 1'b1;
        end else if (armed_q) begin
            cnt_q <= cnt_q - TW'(1);
            if (cnt_q == TW'(1)) begin
                armed_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/est_storm_bank.sv
// Module: per-pin counters of back-to-back EOI-driven redeliveries.
// An update on a pin increments (eligible) or zeroes (not eligible) its
// counter; reaching STORM_LIMIT raises limit_hit and zeroes the counter.
// Assumes: at most one pin updated per cycle; STORM_LIMIT >= 2.
module est_storm_bank #(
    parameter int NUM_PINS    = 24,
    parameter int STORM_LIMIT = 10000,
    parameter int PIN_W       = $clog2(NUM_PINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [PIN_W-1:0] upd_pin,
    input  logic             upd_eligible,
    output logic             limit_hit
);
    localparam int CW = $clog2(STORM_LIMIT + 1);

    logic [CW-1:0] cnt_q [NUM_PINS];

    // A redelivery that would reach the limit is the storm trigger.
    assign limit_hit = upd_en && upd_eligible &&
                       (cnt_q[upd_pin] == CW'(STORM_LIMIT - 1));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_cnt
        // Per-pin counter: count, zero on hit, zero when not eligible.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q[p] <= '0;
            end else if (upd_en && (upd_pin == PIN_W'(p))) begin
                if (!upd_eligible || limit_hit) begin
                    cnt_q[p] <= '0;
                end else begin
                    cnt_q[p] <= cnt_q[p] + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/est_scan_ctrl.sv
// Module: scan sequencer. Accepts a broadcast or starts a due sweep, then
// steps a pin index from 0 to NUM_PINS-1, one pin per cycle.
// Assumes: a due sweep has priority over a new broadcast.
module est_scan_ctrl
    import est_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             eoi_is_level,
    input  logic             directed_eoi,
    input  logic             expire,
    output logic             eoi_ready,
    output logic             busy,
    output logic             in_eoi,
    output logic             in_sweep,
    output logic [PIN_W-1:0] idx,
    output logic [VEC_W-1:0] cur_vector,
    output logic             cur_level,
    output logic             cur_directed
);
    est_state_e state_q;
    logic       due_q;
    logic       start_sweep;
    logic       last_pin;

    assign busy        = (state_q != ST_IDLE);
    assign in_eoi      = (state_q == ST_EOI);
    assign in_sweep    = (state_q == ST_SWEEP);
    assign eoi_ready   = (state_q == ST_IDLE) && !due_q;
    assign start_sweep = (state_q == ST_IDLE) && due_q;
    assign last_pin    = (idx == PIN_W'(NUM_PINS - 1));

    // Remember a timer expiry until the sweep can start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            due_q <= 1'b0;
        end else begin
            due_q <= (due_q && !start_sweep) || expire;
        end
    end

    // Walk the pins for a broadcast or a sweep, latching broadcast fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            idx          <= '0;
            cur_vector   <= '0;
            cur_level    <= 1'b0;
            cur_directed <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    idx <= '0;
                    if (start_sweep) begin
                        state_q <= ST_SWEEP;
                    end else if (eoi_valid) begin
                        state_q      <= ST_EOI;
                        cur_vector   <= eoi_vector;
                        cur_level    <= eoi_is_level;
                        cur_directed <= directed_eoi;
                    end
                end
                default: begin
                    if (last_pin) begin
                        state_q <= ST_IDLE;
                        idx     <= '0;
                    end else begin
                        idx <= idx + PIN_W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/eoi_storm_throttle.sv
// Module: EOI broadcast handler with storm throttle (top).
// Per scanned pin: acknowledge on vector match, clear remote IRR for a
// non-directed level EOI, redeliver a pending unmasked pin, and defer to a
// timed sweep once a pin has redelivered STORM_LIMIT times back to back.
// Assumes: the table owner applies rirr_clear and the delivery engine
// takes every svc_valid without back-pressure.
module eoi_storm_throttle #(
    parameter int NUM_PINS     = 24,
    parameter int VEC_W        = 8,
    parameter int STORM_LIMIT  = 10000,
    parameter int DEFER_CYCLES = 1250000,
    localparam int PIN_W       = $clog2(NUM_PINS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      eoi_valid,
    output logic                      eoi_ready,
    input  logic [VEC_W-1:0]          eoi_vector,
    input  logic                      eoi_is_level,
    input  logic                      directed_eoi,
    input  logic [NUM_PINS*VEC_W-1:0] ent_vector,
    input  logic [NUM_PINS-1:0]       ent_level,
    input  logic [NUM_PINS-1:0]       ent_mask,
    input  logic [NUM_PINS-1:0]       ent_rirr,
    input  logic [NUM_PINS-1:0]       ent_pend,
    output logic [NUM_PINS-1:0]       ack_pulse,
    output logic [NUM_PINS-1:0]       rirr_clear,
    output logic                      svc_valid,
    output logic [PIN_W-1:0]          svc_pin,
    output logic                      busy
);
    logic             in_eoi;
    logic             in_sweep;
    logic [PIN_W-1:0] idx;
    logic [VEC_W-1:0] cur_vector;
    logic             cur_level;
    logic             cur_directed;
    logic             expire;
    logic             limit_hit;
    logic [VEC_W-1:0] pin_vector;
    logic             hit_vec;
    logic             do_clear;
    logic             eligible;
    logic             eoi_svc;
    logic             sweep_svc;
    logic             arm;

    est_scan_ctrl #(
        .NUM_PINS (NUM_PINS),
        .VEC_W    (VEC_W),
        .PIN_W    (PIN_W)
    ) scan_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .eoi_valid    (eoi_valid),
        .eoi_vector   (eoi_vector),
        .eoi_is_level (eoi_is_level),
        .directed_eoi (directed_eoi),
        .expire       (expire),
        .eoi_ready    (eoi_ready),
        .busy         (busy),
        .in_eoi       (in_eoi),
        .in_sweep     (in_sweep),
        .idx          (idx),
        .cur_vector   (cur_vector),
        .cur_level    (cur_level),
        .cur_directed (cur_directed)
    );

    // Per-pin decision for the pin under the scan index.
    always_comb begin
        pin_vector = ent_vector[idx*VEC_W +: VEC_W];
        hit_vec    = in_eoi && (pin_vector == cur_vector);
        do_clear   = hit_vec && cur_level && !cur_directed;
        eligible   = !ent_mask[idx] && ent_pend[idx];
        eoi_svc    = do_clear && eligible && !limit_hit;
        arm        = do_clear && eligible && limit_hit;
        sweep_svc  = in_sweep && ent_level[idx] && ent_pend[idx] &&
                     !ent_rirr[idx] && !ent_mask[idx];
    end

    est_storm_bank #(
        .NUM_PINS    (NUM_PINS),
        .STORM_LIMIT (STORM_LIMIT),
        .PIN_W       (PIN_W)
    ) bank_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd_en       (do_clear),
        .upd_pin      (idx),
        .upd_eligible (eligible),
        .limit_hit    (limit_hit)
    );

    est_defer_timer #(
        .DEFER_CYCLES (DEFER_CYCLES)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm),
        .expire (expire)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign ack_pulse[p]  = hit_vec  && (idx == PIN_W'(p));
        assign rirr_clear[p] = do_clear && (idx == PIN_W'(p));
    end

    assign svc_valid = eoi_svc || sweep_svc;
    assign svc_pin   = idx;
endmodule

// File: rtl/est_checker.sv
// Module: property checker for eoi_storm_throttle, attached by bind.
// Assumes: observes top-level ports only.
module est_checker #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                eoi_valid,
    input logic                eoi_ready,
    input logic [NUM_PINS-1:0] ent_mask,
    input logic [NUM_PINS-1:0] ent_pend,
    input logic [NUM_PINS-1:0] ack_pulse,
    input logic [NUM_PINS-1:0] rirr_clear,
    input logic                svc_valid,
    input logic [PIN_W-1:0]    svc_pin,
    input logic                busy
);
    // R1
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_pulse));

    // R2
    clr_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_clear & ~ack_pulse) == '0);

    // R3
    svc_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_valid |-> (!ent_mask[svc_pin] && ent_pend[svc_pin]));

    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_ready |-> !busy);

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_ready) |=> busy);

    // R8
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !svc_valid && ack_pulse == '0));
endmodule

bind eoi_storm_throttle est_checker #(
    .NUM_PINS (NUM_PINS),
    .PIN_W    (PIN_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .eoi_valid  (eoi_valid),
    .eoi_ready  (eoi_ready),
    .ent_mask   (ent_mask),
    .ent_pend   (ent_pend),
    .ack_pulse  (ack_pulse),
    .rirr_clear (rirr_clear),
    .svc_valid  (svc_valid),
    .svc_pin    (svc_pin),
    .busy       (busy)
);

// File: tb/eoi_storm_throttle_tb_top.sv
// Bench: vector table for match/clear/service rules, then directed tests
// for storm threshold, deferred sweep, timer restart and reset.
module eoi_storm_throttle_tb_top;
    localparam int NP    = 4;
    localparam int VW    = 8;
    localparam int LIMIT = 4;
    localparam int DLY   = 60;

    typedef struct packed {
        logic [7:0] vec;
        logic       lvl;
        logic       dir;
        logic [3:0] mask;
        logic [3:0] pend;
        logic [3:0] e_ack;
        logic [3:0] e_clr;
        logic [3:0] e_svc;
    } row_t;

    // Pins 0,1,2 carry vector 0x30 (pin1 edge), pin3 carries 0x41.
    localparam row_t ROWS [7] = '{
        '{8'h30, 1'b1, 1'b0, 4'b0000, 4'b0101, 4'b0111, 4'b0111, 4'b0101},
        '{8'h30, 1'b1, 1'b1, 4'b0000, 4'b0101, 4'b0111, 4'b0000, 4'b0000},
        '{8'h30, 1'b0, 1'b0, 4'b0000, 4'b0101, 4'b0111, 4'b0000, 4'b0000},
        '{8'h41, 1'b1, 1'b0, 4'b0000, 4'b1000, 4'b1000, 4'b1000, 4'b1000},
        '{8'h55, 1'b1, 1'b0, 4'b0000, 4'b1111, 4'b0000, 4'b0000, 4'b0000},
        '{8'h30, 1'b1, 1'b0, 4'b0100, 4'b0101, 4'b0111, 4'b0111, 4'b0001},
        '{8'h30, 1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0111, 4'b0111, 4'b0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              eoi_valid = 1'b0;
    logic              eoi_ready;
    logic [VW-1:0]     eoi_vector = '0;
    logic              eoi_is_level = 1'b0;
    logic              directed_eoi = 1'b0;
    logic [NP*VW-1:0]  ent_vector = {8'h41, 8'h30, 8'h30, 8'h30};
    logic [NP-1:0]     ent_level = 4'b1101;
    logic [NP-1:0]     ent_mask = '0;
    logic [NP-1:0]     ent_rirr = '0;
    logic [NP-1:0]     ent_pend = '0;
    logic [NP-1:0]     ack_pulse;
    logic [NP-1:0]     rirr_clear;
    logic              svc_valid;
    logic [1:0]        svc_pin;
    logic              busy;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int busy_n = 0;
    int ack_n [NP];
    int clr_n [NP];
    int svc_n [NP];
    int s_ack [NP];
    int s_clr [NP];
    int s_svc [NP];
    int s_busy = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    eoi_storm_throttle #(
        .NUM_PINS     (NP),
        .VEC_W        (VW),
        .STORM_LIMIT  (LIMIT),
        .DEFER_CYCLES (DLY)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .eoi_valid    (eoi_valid),
        .eoi_ready    (eoi_ready),
        .eoi_vector   (eoi_vector),
        .eoi_is_level (eoi_is_level),
        .directed_eoi (directed_eoi),
        .ent_vector   (ent_vector),
        .ent_level    (ent_level),
        .ent_mask     (ent_mask),
        .ent_rirr     (ent_rirr),
        .ent_pend     (ent_pend),
        .ack_pulse    (ack_pulse),
        .rirr_clear   (rirr_clear),
        .svc_valid    (svc_valid),
        .svc_pin      (svc_pin),
        .busy         (busy)
    );

    initial begin
        for (int i = 0; i < NP; i++) begin
            ack_n[i] = 0; clr_n[i] = 0; svc_n[i] = 0;
            s_ack[i] = 0; s_clr[i] = 0; s_svc[i] = 0;
        end
    end

    // Output monitor, sampled mid-cycle.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (busy) busy_n <= busy_n + 1;
        for (int i = 0; i < NP; i++) begin
            if (ack_pulse[i])  ack_n[i] <= ack_n[i] + 1;
            if (rirr_clear[i]) clr_n[i] <= clr_n[i] + 1;
        end
        if (svc_valid) svc_n[svc_pin] <= svc_n[svc_pin] + 1;
    end

    task automatic snap();
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            s_ack[i] = ack_n[i]; s_clr[i] = clr_n[i]; s_svc[i] = svc_n[i];
        end
        s_busy = busy_n;
    endtask

    function automatic logic [3:0] ack_mask();
        for (int i = 0; i < NP; i++) ack_mask[i] = (ack_n[i] - s_ack[i]) == 1;
    endfunction
    function automatic logic [3:0] clr_mask();
        for (int i = 0; i < NP; i++) clr_mask[i] = (clr_n[i] - s_clr[i]) == 1;
    endfunction
    function automatic logic [3:0] svc_mask();
        for (int i = 0; i < NP; i++) svc_mask[i] = (svc_n[i] - s_svc[i]) == 1;
    endfunction
    function automatic int svc_total();
        svc_total = 0;
        for (int i = 0; i < NP; i++) svc_total += svc_n[i] - s_svc[i];
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_eoi(logic [7:0] v, logic lvl, logic dir);
        @(negedge clk);
        while (!eoi_ready) @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v; eoi_is_level = lvl; directed_eoi = dir;
        @(negedge clk);
        eoi_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic storm_pin3(output int t_hit);
        for (int k = 0; k < LIMIT - 1; k++) send_eoi(8'h41, 1'b1, 1'b0);
        snap();
        send_eoi(8'h41, 1'b1, 1'b0);
        t_hit = cyc;
    endtask

    initial begin
        int t1;
        int t2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 R9 reset state
        check(eoi_ready && !busy && !svc_valid && ack_pulse == 0, "R9 reset idle",
              {eoi_ready, busy, svc_valid}, 3'b100);

        // Table of match / clear / service cases (R1 R2 R3 R4)
        foreach (ROWS[r]) begin
            ent_mask = ROWS[r].mask;
            ent_pend = ROWS[r].pend;
            snap();
            send_eoi(ROWS[r].vec, ROWS[r].lvl, ROWS[r].dir);
            check(ack_mask() == ROWS[r].e_ack, "R1 ack pins", ack_mask(), ROWS[r].e_ack);
            check(clr_mask() == ROWS[r].e_clr, "R2 clear pins", clr_mask(), ROWS[r].e_clr);
            check(svc_mask() == ROWS[r].e_svc && svc_total() == $countones(ROWS[r].e_svc),
                  "R3 service pins", svc_mask(), ROWS[r].e_svc);
            check(busy_n - s_busy == NP, "R9 busy length", busy_n - s_busy, NP);
        end

        // R4: idle pin zeroes pin3 count (was 1), so a full run is needed
        ent_mask = '0; ent_pend = '0;
        send_eoi(8'h41, 1'b1, 1'b0);
        ent_pend = 4'b1000;
        snap();
        for (int k = 0; k < LIMIT - 1; k++) send_eoi(8'h41, 1'b1, 1'b0);
        check(svc_n[3] - s_svc[3] == LIMIT - 1, "R4 count restarted", svc_n[3] - s_svc[3], LIMIT - 1);
        snap();
        send_eoi(8'h41, 1'b1, 1'b0);
        t1 = cyc;
        check(svc_total() == 0, "R5 limit suppresses service", svc_total(), 0);

        // R6: sweep picks level, pending, unmasked, remote-IRR-clear pins
        ent_pend = 4'b1111; ent_rirr = 4'b0001;
        snap();
        wait_until(t1 + DLY - 5);
        check(svc_total() == 0, "R6 sweep not early", svc_total(), 0);
        wait_until(t1 + DLY + 12);
        check(svc_mask() == 4'b1100 && svc_total() == 2, "R6 sweep pins", svc_mask(), 4'b1100);
        ent_rirr = '0;

        // R5: counter was zeroed at the hit, so a full run is needed again
        ent_pend = 4'b1000;
        snap();
        for (int k = 0; k < LIMIT - 1; k++) send_eoi(8'h41, 1'b1, 1'b0);
        check(svc_n[3] - s_svc[3] == LIMIT - 1, "R5 count zeroed at hit", svc_n[3] - s_svc[3], LIMIT - 1);
        snap();
        send_eoi(8'h41, 1'b1, 1'b0);
        t1 = cyc;
        check(svc_total() == 0, "R5 second storm", svc_total(), 0);

        // R7: second storm restarts the delay
        repeat (10) @(negedge clk);
        storm_pin3(t2);
        snap();
        wait_until(t1 + DLY + 10);
        check(svc_total() == 0, "R7 old expiry ignored", svc_total(), 0);
        wait_until(t2 + DLY + 12);
        check(svc_mask() == 4'b1000 && svc_total() == 1, "R7 restarted sweep", svc_mask(), 4'b1000);

        // R8: reset cancels a scheduled sweep and clears counts
        storm_pin3(t1);
        send_eoi(8'h41, 1'b1, 1'b0);
        send_eoi(8'h41, 1'b1, 1'b0);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(eoi_ready && !busy, "R8 idle after reset", {eoi_ready, busy}, 2'b10);
        snap();
        repeat (DLY + 20) @(negedge clk);
        check(svc_total() == 0, "R8 sweep cancelled", svc_total(), 0);
        snap();
        for (int k = 0; k < LIMIT - 1; k++) send_eoi(8'h41, 1'b1, 1'b0);
        check(svc_n[3] - s_svc[3] == LIMIT - 1, "R8 counts cleared", svc_n[3] - s_svc[3], LIMIT - 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule